// File: doc/BRIEF.md
# Delay-Line Interpolating Interval Timer

This block measures the time between a start event and a stop event with a resolution finer than one period of its clock. A counter running on the clock supplies the coarse part of the interval. Each event edge also travels down an external chain of delay elements whose taps reach the block as a thermometer vector. The block captures that vector when it raises its capture strobe. The number of elements the edge has already crossed gives a fine correction, one for each end of the interval.

A single tap-capture register and decoder serve both ends. The start-side snapshot is captured and decoded during the coarse count. The same register is then captured again for the stop side. The result is the coarse count times the clock period, plus the start fine count times the element delay, minus the stop fine count times the element delay. It is reported in units of 0.1 ns, with a 100 ns clock period (1000 units) and 4.3 ns per element (43 units). Because of the two fine corrections, the residual error stays within two element delays.

Top module: `interp_interval_timer`

## Requirements
- R1: While reset is low and after it is released, `tap_strobe` and `result_valid` are 0, and `coarse_count`, `fine_start`, `fine_stop` and `interval_dps` are 0.
- R2: When the block is idle and `start_evt` is high at a clock edge, `tap_strobe` is high for exactly the next cycle. The tap vector is captured at the end of that cycle as the start-side snapshot.
- R3: For a clean thermometer snapshot, with taps 0..k-1 at 1 and the rest at 0, the fine count is k, for any k from 0 to 32. Bit 0 of `taps` is the first element the edge reaches.
- R4: A single 0 inside the run of ones (a bubble) does not shorten the fine count. A 1 that sits above the run with two or more 0 taps between them is ignored.
- R5: One capture register serves both sides. `tap_strobe` is high for exactly two cycles per measurement: the start-side cycle first, then the stop-side cycle. Tap values present in any other cycle have no effect on the results.
- R6: `coarse_count` equals the number of clock edges from the start-side capture edge (exclusive) to the stop-side capture edge (inclusive). It saturates at its maximum value.
- R7: `interval_dps` equals coarse·1000 + (fine_start − fine_stop)·43, as a signed 48-bit value.
- R8: `result_valid` is a one-cycle pulse two cycles after the stop-side strobe cycle. In the same cycle the four result outputs show the new measurement, and they keep those values afterwards.
- R9: `stop_evt` is ignored unless a coarse count is running, and `start_evt` is ignored while a measurement is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_evt | input | 1 | Start event, sampled at clock edges |
| stop_evt | input | 1 | Stop event, sampled at clock edges |
| taps | input | NTAPS (32) | Delay chain tap states, thermometer coded from bit 0 |
| tap_strobe | output | 1 | High in the cycle whose closing edge captures the taps |
| coarse_count | output | CW (32) | Coarse clock edges counted in the last measurement |
| fine_start | output | FW (6) | Start-side fine count |
| fine_stop | output | FW (6) | Stop-side fine count |
| interval_dps | output | RW (48) | Combined interval in 0.1 ns units, signed |
| result_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
Two events can meet in the same cycle: a stray start arriving during the coarse count, and the coarse count advancing in the cycle that samples stop. The bench pulses `start_evt` at a random point inside the counting window. It counts strobes at the port to confirm that no extra capture occurred, and checks that the coarse count still matches the strobe spacing. The bench also offers random garbage on `taps` in every cycle except the strobe cycles, so any capture outside the strobe cycles shows up as a wrong fine count.

// File: rtl/iit_pkg.sv
// Shared types for the interpolating interval timer.
package iit_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ARM_START = 3'd1,
        ST_COUNT     = 3'd2,
        ST_ARM_STOP  = 3'd3,
        ST_DONE      = 3'd4
    } iit_state_e;
endpackage

// File: rtl/thermo_bubble_decoder.sv
// Converts a captured delay-chain snapshot into a fine count.
// Assumes the edge enters at bit 0. A tap counts only if it is set and one
// of the two taps below it is set: a single bubble is bridged, and a set
// tap above a gap of two or more zeros is ignored. The result is
// (highest qualifying tap index + 1), or 0 when no tap qualifies.
module thermo_bubble_decoder #(
    parameter int NTAPS = 32,
    parameter int FW    = $clog2(NTAPS + 1)
) (
    input  logic [NTAPS-1:0] snap,
    output logic [FW-1:0]    fine
);
    logic [NTAPS-1:0] qual;

    // Qualify each tap against its two lower neighbours.
    for (genvar g = 0; g < NTAPS; g++) begin : g_qual
        if (g == 0) begin : g_first
            assign qual[g] = snap[g];
        end else if (g == 1) begin : g_second
            assign qual[g] = snap[g] & snap[g-1];
        end else begin : g_rest
            assign qual[g] = snap[g] & (snap[g-1] | snap[g-2]);
        end
    end

    // Pick the highest qualifying tap.
    always_comb begin
        fine = '0;
        for (int i = 0; i < NTAPS; i++) begin
            if (qual[i]) fine = FW'(i + 1);
        end
    end
endmodule

// File: rtl/interval_ctrl.sv
// Sequencer for one measurement: idle, start capture, coarse counting,
// stop capture, result. Assumes events are already synchronous to clk.
// The coarse counter clears on the start capture edge, then advances on
// every counting edge and on the stop capture edge, saturating at all ones.
module interval_ctrl
    import iit_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_evt,
    input  logic          stop_evt,
    output iit_state_e    state,
    output logic          strobe,
    output logic [CW-1:0] coarse
);
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] coarse_inc;

    // Saturating increment of the coarse counter.
    always_comb coarse_inc = (coarse == CMAX) ? coarse : coarse + 1'b1;

    // Capture strobe in either arm state.
    always_comb strobe = (state == ST_ARM_START) || (state == ST_ARM_STOP);

    // State and coarse counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            coarse <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_evt) state <= ST_ARM_START;
                end
                ST_ARM_START: begin
                    coarse <= '0;
                    state  <= ST_COUNT;
                end
                ST_COUNT: begin
                    coarse <= coarse_inc;
                    if (stop_evt) state <= ST_ARM_STOP;
                end
                ST_ARM_STOP: begin
                    coarse <= coarse_inc;
                    state  <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: an accepted start leads to a strobe cycle.
    p_strobe_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_evt) |=> strobe);

    // R9: stop seen in idle keeps the sequencer idle.
    p_idle_stop_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_evt && stop_evt) |=> (state == ST_IDLE));

    // R6: the counter advances by one per counting edge below saturation.
    p_coarse_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && coarse != CMAX) |=> (coarse == $past(coarse) + 1'b1));

    // R5: strobe cycles never run back to back.
    p_strobe_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/interval_combine.sv
// Forms the signed interval in 0.1 ns units from the coarse count and the
// two fine counts. Purely combinational; the caller registers the result.
module interval_combine #(
    parameter int CW          = 32,
    parameter int FW          = 6,
    parameter int RW          = 48,
    parameter int COARSE_UNIT = 1000,
    parameter int FINE_UNIT   = 43
) (
    input  logic [CW-1:0]        coarse,
    input  logic [FW-1:0]        fine_a,
    input  logic [FW-1:0]        fine_b,
    output logic signed [RW-1:0] result
);
    localparam logic signed [RW-1:0] CU = RW'(COARSE_UNIT);
    localparam logic signed [RW-1:0] FU = RW'(FINE_UNIT);

    logic signed [RW-1:0] c_ext;
    logic signed [RW-1:0] f_diff;

    // Widen the operands, take the fine difference, scale and sum.
    always_comb begin
        c_ext  = signed'(RW'(coarse));
        f_diff = signed'(RW'(fine_a)) - signed'(RW'(fine_b));
        result = c_ext * CU + f_diff * FU;
    end
endmodule

// File: rtl/interp_interval_timer.sv
// Top of the interpolating interval timer. One tap snapshot register is
// loaded on each strobe edge and feeds one decoder. The start fine count
// is stored on the first counting edge, while the stop-side snapshot has
// not yet been taken. The stop fine count and the combined result are
// stored on the result edge.
module interp_interval_timer
    import iit_pkg::*;
#(
    parameter int NTAPS       = 32,
    parameter int CW          = 32,
    parameter int RW          = 48,
    parameter int COARSE_UNIT = 1000,
    parameter int FINE_UNIT   = 43,
    localparam int FW         = $clog2(NTAPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_evt,
    input  logic                 stop_evt,
    input  logic [NTAPS-1:0]     taps,
    output logic                 tap_strobe,
    output logic [CW-1:0]        coarse_count,
    output logic [FW-1:0]        fine_start,
    output logic [FW-1:0]        fine_stop,
    output logic signed [RW-1:0] interval_dps,
    output logic                 result_valid
);
    iit_state_e           state;
    logic [CW-1:0]        coarse;
    logic [NTAPS-1:0]     snap;
    logic [FW-1:0]        fine_dec;
    logic signed [RW-1:0] combined;

    interval_ctrl #(.CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .state     (state),
        .strobe    (tap_strobe),
        .coarse    (coarse)
    );

    thermo_bubble_decoder #(.NTAPS(NTAPS), .FW(FW)) u_dec (
        .snap (snap),
        .fine (fine_dec)
    );

    interval_combine #(
        .CW(CW), .FW(FW), .RW(RW),
        .COARSE_UNIT(COARSE_UNIT), .FINE_UNIT(FINE_UNIT)
    ) u_comb (
        .coarse (coarse),
        .fine_a (fine_start),
        .fine_b (fine_dec),
        .result (combined)
    );

    // Single shared capture of the delay chain taps.
    always_ff @(posedge clk) begin
        if (!rst_n)          snap <= '0;
        else if (tap_strobe) snap <= taps;
    end

    // Store the start fine count on the first counting edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   fine_start <= '0;
        else if (state == ST_COUNT && coarse == '0)   fine_start <= fine_dec;
    end

    // Publish the stop fine count, coarse count and combined value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_stop    <= '0;
            coarse_count <= '0;
            interval_dps <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= (state == ST_DONE);
            if (state == ST_DONE) begin
                fine_stop    <= fine_dec;
                coarse_count <= coarse;
                interval_dps <= combined;
            end
        end
    end

    // R3: a decoded fine count never exceeds the tap count.
    p_fine_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_start <= FW'(NTAPS)) && (fine_stop <= FW'(NTAPS)));

    // R8: the result flag is a single-cycle pulse.
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R8: published results hold while no new result is flagged.
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!result_valid && $past(!result_valid)) |-> $stable(interval_dps));
endmodule

// File: tb/tb_interp_interval_timer.sv
// Bench: directed corners plus seeded random measurements. A behavioural
// delay chain drives a thermometer pattern in strobe cycles and garbage
// in all other cycles.
module tb_interp_interval_timer;
    localparam int NTAPS = 32;
    localparam int CW    = 32;
    localparam int RW    = 48;
    localparam int FW    = $clog2(NTAPS + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_evt = 1'b0;
    logic                 stop_evt = 1'b0;
    logic [NTAPS-1:0]     taps = '0;
    logic                 tap_strobe;
    logic [CW-1:0]        coarse_count;
    logic [FW-1:0]        fine_start;
    logic [FW-1:0]        fine_stop;
    logic signed [RW-1:0] interval_dps;
    logic                 result_valid;

    int checks = 0;
    int errors = 0;
    int nstrobe = 0;

    interp_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .taps(taps), .tap_strobe(tap_strobe), .coarse_count(coarse_count),
        .fine_start(fine_start), .fine_stop(fine_stop),
        .interval_dps(interval_dps), .result_valid(result_valid)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (tap_strobe) nstrobe++;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural chain: k elements crossed, optional bubble and stray tap.
    function automatic logic [NTAPS-1:0] chain(int k, int bub, int stray);
        logic [NTAPS-1:0] v = '0;
        for (int i = 0; i < k; i++) v[i] = 1'b1;
        if (bub >= 0) v[bub] = 1'b0;
        if (stray >= 0) v[stray] = 1'b1;
        return v;
    endfunction

    function automatic longint expect_dps(int n0, int k1, int k2);
        return longint'(n0) * 1000 + longint'(k1 - k2) * 43;
    endfunction

    task automatic measure(int k1, int b1, int s1, int k2, int b2, int s2,
                           int gap, bit poke);
        int s0;
        int poke_at;
        longint exp_dps;
        s0 = nstrobe;
        poke_at = (gap > 1) ? $urandom_range(1, gap - 1) : 0;
        @(negedge clk); start_evt = 1'b1; taps = $urandom;
        @(negedge clk); start_evt = 1'b0;
        chk(tap_strobe === 1'b1, "R2", "start strobe", tap_strobe, 1);
        taps = chain(k1, b1, s1);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            taps = $urandom;
            start_evt = poke && (i + 1 == poke_at);
            chk(tap_strobe === 1'b0, "R5", "no strobe while counting", tap_strobe, 0);
        end
        start_evt = 1'b0;
        stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
        chk(tap_strobe === 1'b1, "R5", "stop strobe", tap_strobe, 1);
        taps = chain(k2, b2, s2);
        @(negedge clk); taps = $urandom;
        chk(result_valid === 1'b0, "R8", "valid not early", result_valid, 0);
        @(negedge clk); taps = $urandom;
        chk(result_valid === 1'b1, "R8", "valid pulse", result_valid, 1);
        chk(coarse_count == CW'(gap + 1), "R6", "coarse count", coarse_count, gap + 1);
        chk(fine_start == FW'(k1), (b1 >= 0 || s1 >= 0) ? "R4" : "R3", "start fine", fine_start, k1);
        chk(fine_stop == FW'(k2), (b2 >= 0 || s2 >= 0) ? "R4" : "R3", "stop fine", fine_stop, k2);
        exp_dps = expect_dps(gap + 1, k1, k2);
        chk(longint'(interval_dps) == exp_dps, "R7", "interval", longint'(interval_dps), exp_dps);
        chk(nstrobe - s0 == 2, poke ? "R9" : "R5", "strobes per measurement", nstrobe - s0, 2);
        @(negedge clk);
        chk(result_valid === 1'b0, "R8", "valid drops", result_valid, 1'b0);
        chk(longint'(interval_dps) == exp_dps, "R8", "result held", longint'(interval_dps), exp_dps);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(tap_strobe === 1'b0 && result_valid === 1'b0, "R1", "flags in reset",
            {tap_strobe, result_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(coarse_count == 0 && fine_start == 0 && fine_stop == 0, "R1", "counts after reset",
            coarse_count + fine_start + fine_stop, 0);
        chk(interval_dps == 0, "R1", "interval after reset", longint'(interval_dps), 0);

        // R9: stop while idle does nothing.
        stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(tap_strobe === 1'b0 && result_valid === 1'b0, "R9", "idle stop ignored",
                {tap_strobe, result_valid}, 0);
        end

        // Directed corners (R3 extremes, R4 bubble/stray, R6 minimum gap).
        measure(0, -1, -1, 32, -1, -1, 1, 1'b0);
        measure(32, -1, -1, 0, -1, -1, 1, 1'b0);
        measure(16, -1, -1, 16, -1, -1, 5, 1'b0);
        measure(20, 7, -1, 3, -1, 9, 8, 1'b0);
        measure(1, -1, 31, 31, 29, -1, 12, 1'b1);

        // Seeded random measurements, half with a stray start (R9).
        for (int n = 0; n < 60; n++) begin
            int k1, k2, b1, b2, s1, s2;
            k1 = $urandom_range(0, NTAPS);
            k2 = $urandom_range(0, NTAPS);
            b1 = (k1 >= 3 && $urandom_range(0, 1) == 1) ? $urandom_range(1, k1 - 2) : -1;
            b2 = (k2 >= 3 && $urandom_range(0, 1) == 1) ? $urandom_range(1, k2 - 2) : -1;
            s1 = (k1 <= NTAPS - 3 && $urandom_range(0, 1) == 1) ? $urandom_range(k1 + 2, NTAPS - 1) : -1;
            s2 = (k2 <= NTAPS - 3 && $urandom_range(0, 1) == 1) ? $urandom_range(k2 + 2, NTAPS - 1) : -1;
            measure(k1, b1, s1, k2, b2, s2, $urandom_range(1, 40), n[0]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule